// File: doc/BRIEF.md
# Single-Cycle MIPS-Subset Processor Core

This block is a 32-bit integer core that fetches, decodes, executes and retires one instruction in every clock cycle. It runs a small MIPS subset: word loads and stores, five register-to-register operations (add, sub, and, or, slt), branch-on-equal and an absolute jump. The core contains a program counter, a 32-entry register file with two read ports and one write port, an ALU with a zero flag, immediate sign extension, branch and jump target adders, and a main decoder. The main decoder drives a 2-bit ALU operation code into a second decoder, and that decoder turns it, together with the funct field for R-type instructions, into a 4-bit ALU control.

Instruction memory and data memory are separate internal word arrays, so a load or store can run in the same cycle as the fetch. Instruction memory has no write port and is filled from outside the design before reset is released. Each cycle the core presents its program counter and a trace of the register write and the memory write it will commit at the next rising edge. A surrounding system or test harness can follow execution through these ports without reaching inside.

Top module: `mips_sc_core`

## Requirements
- R1: `rst` is an active-high synchronous reset. At a rising edge with `rst` high, the PC becomes 0 and all 32 registers become 0. While `rst` is high, `rf_we_o` and `mem_we_o` stay low and nothing is written. Data memory keeps its contents across reset.
- R2: Fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0] and immediate [15:0]. Every instruction other than a taken beq or a j sets the next PC to PC + 4. An opcode outside {0x00, 0x02, 0x04, 0x23, 0x2B} writes nothing and advances the PC by 4.
- R3: Opcode 0x00 (R-type) writes rd. The result is selected by funct: 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x2A slt. slt compares the operands as signed 32-bit values and writes 1 or 0. Any other funct writes nothing.
- R4: Register 0 always reads as 0. An instruction whose destination is register 0 raises no `rf_we_o` and changes nothing.
- R5: Opcode 0x23 (lw) writes rt with the data word selected by rs plus the sign-extended immediate. Address bits [1:0] are ignored, and the word index wraps modulo the data memory depth.
- R6: Opcode 0x2B (sw) writes rt's value to the data word chosen by the same address rule. It raises `mem_we_o` with that byte address and data, and it writes no register.
- R7: Opcode 0x04 (beq) compares rs and rt. If they are equal, the next PC is PC + 4 + (sign-extended immediate << 2). Otherwise it is PC + 4.
- R8: Opcode 0x02 (j) sets the next PC to bits [31:28] of PC + 4, followed by instruction bits [25:0], followed by two zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | A register write commits at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value written to the destination register |
| mem_we_o | output | 1 | A data memory write commits at the next edge |
| mem_addr_o | output | 32 | Byte address computed by the ALU for load or store |
| mem_wdata_o | output | 32 | Store data (rt value) |

## Verification
A wrong next-PC choice, such as a branch taken on unequal operands or a bad jump concatenation, shows on `pc_o` in the very next cycle. From then on every following trace entry comes from the wrong instruction. A wrong ALU control, a wrong sign extension or a bad register write shows on `rf_wdata_o` or `mem_addr_o` in the cycle that executes the instruction. A corrupted register or memory word stays hidden until a later instruction reads it, which is why the random program is run for hundreds of cycles and every cycle's trace is compared with a reference model.

// File: rtl/mips_pkg.sv
package mips_pkg;

    localparam int XLEN = 32;
    localparam int NREGS = 32;
    localparam int RAW = $clog2(NREGS);

    // primary opcodes
    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_JUMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    // R-type function codes
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        CLS_RTYPE,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH,
        CLS_JUMP,
        CLS_NONE
    } instr_cls_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } alu_op_e;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_NOR = 4'b1100
    } alu_ctrl_e;

    typedef struct packed {
        logic    reg_write;
        logic    dst_is_rd;
        logic    b_is_imm;
        logic    mem_write;
        logic    wb_from_mem;
        logic    branch;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/mips_regfile.sv
module mips_regfile
    import mips_pkg::*;
#(
    parameter int N = NREGS,
    parameter int W = XLEN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] waddr,
    input  logic [W-1:0]         wdata,
    input  logic [$clog2(N)-1:0] raddr_a,
    input  logic [$clog2(N)-1:0] raddr_b,
    output logic [W-1:0]         rdata_a,
    output logic [W-1:0]         rdata_b
);
    localparam int AW = $clog2(N);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (waddr != AW'(0))) begin
            regs[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_a = (raddr_a == AW'(0)) ? '0 : regs[raddr_a];
        rdata_b = (raddr_b == AW'(0)) ? '0 : regs[raddr_b];
    end

endmodule

// File: rtl/mips_alu.sv
module mips_alu
    import mips_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_ctrl_e    op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            ALU_NOR: y = ~(a | b);
            default: y = '0;
        endcase
        zero = (y == '0);
    end

endmodule

// File: rtl/mips_ctrl.sv
module mips_ctrl
    import mips_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl,
    output alu_ctrl_e  alu_ctrl
);
    instr_cls_e cls;
    ctrl_t      main_ctrl;
    logic       funct_ok;

    // first level: classify the opcode
    always_comb begin
        unique case (opcode)
            OPC_RTYPE: cls = CLS_RTYPE;
            OPC_LOAD:  cls = CLS_LOAD;
            OPC_STORE: cls = CLS_STORE;
            OPC_BEQ:   cls = CLS_BRANCH;
            OPC_JUMP:  cls = CLS_JUMP;
            default:   cls = CLS_NONE;
        endcase
    end

    // main decoder outputs per class
    always_comb begin
        main_ctrl = '{reg_write: 1'b0, dst_is_rd: 1'b0, b_is_imm: 1'b0,
                      mem_write: 1'b0, wb_from_mem: 1'b0, branch: 1'b0,
                      jump: 1'b0, alu_op: AOP_ADD};
        unique case (cls)
            CLS_RTYPE: begin
                main_ctrl.reg_write = 1'b1;
                main_ctrl.dst_is_rd = 1'b1;
                main_ctrl.alu_op    = AOP_FUNCT;
            end
            CLS_LOAD: begin
                main_ctrl.reg_write   = 1'b1;
                main_ctrl.b_is_imm    = 1'b1;
                main_ctrl.wb_from_mem = 1'b1;
            end
            CLS_STORE: begin
                main_ctrl.b_is_imm  = 1'b1;
                main_ctrl.mem_write = 1'b1;
            end
            CLS_BRANCH: begin
                main_ctrl.branch = 1'b1;
                main_ctrl.alu_op = AOP_SUB;
            end
            CLS_JUMP: begin
                main_ctrl.jump = 1'b1;
            end
            default: ;
        endcase
    end

    // second level: ALU operation from alu_op and funct
    always_comb begin
        funct_ok = 1'b1;
        unique case (main_ctrl.alu_op)
            AOP_ADD: alu_ctrl = ALU_ADD;
            AOP_SUB: alu_ctrl = ALU_SUB;
            AOP_FUNCT: begin
                unique case (funct)
                    FN_ADD:  alu_ctrl = ALU_ADD;
                    FN_SUB:  alu_ctrl = ALU_SUB;
                    FN_AND:  alu_ctrl = ALU_AND;
                    FN_OR:   alu_ctrl = ALU_OR;
                    FN_SLT:  alu_ctrl = ALU_SLT;
                    default: begin
                        alu_ctrl = ALU_AND;
                        funct_ok = 1'b0;
                    end
                endcase
            end
            default: alu_ctrl = ALU_ADD;
        endcase
    end

    // an unknown funct suppresses the register write
    always_comb begin
        ctrl           = main_ctrl;
        ctrl.reg_write = main_ctrl.reg_write & funct_ok;
    end

endmodule

// File: rtl/mips_sc_core.sv
module mips_sc_core
    import mips_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] pc_o,
    output logic        rf_we_o,
    output logic [4:0]  rf_waddr_o,
    output logic [31:0] rf_wdata_o,
    output logic        mem_we_o,
    output logic [31:0] mem_addr_o,
    output logic [31:0] mem_wdata_o
);
    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc_q, pc_next, pc_plus4;
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] imm_sext, br_target, j_target;
    logic [XLEN-1:0] rd_a, rd_b, alu_b, alu_y, dmem_rdata, wb_data;
    logic [RAW-1:0]  wr_addr;
    logic            alu_zero;
    logic            rf_we_eff, dm_we_eff;
    ctrl_t           ctrl;
    alu_ctrl_e       alu_ctrl;

    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) begin
            imem[i] = '0;
        end
    end

    // program counter
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign instr    = imem[pc_q[IAW+1:2]];
    assign pc_plus4 = pc_q + 32'd4;
    assign imm_sext = {{16{instr[15]}}, instr[15:0]};
    assign br_target = pc_plus4 + {imm_sext[29:0], 2'b00};
    assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};

    mips_ctrl i_ctrl (
        .opcode   (instr[31:26]),
        .funct    (instr[5:0]),
        .ctrl     (ctrl),
        .alu_ctrl (alu_ctrl)
    );

    assign wr_addr   = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
    assign rf_we_eff = ctrl.reg_write & ~rst;
    assign dm_we_eff = ctrl.mem_write & ~rst;

    mips_regfile #(.N(NREGS), .W(XLEN)) i_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we_eff),
        .waddr   (wr_addr),
        .wdata   (wb_data),
        .raddr_a (instr[25:21]),
        .raddr_b (instr[20:16]),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    assign alu_b = ctrl.b_is_imm ? imm_sext : rd_b;

    mips_alu #(.W(XLEN)) i_alu (
        .a    (rd_a),
        .b    (alu_b),
        .op   (alu_ctrl),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data memory
    assign dmem_rdata = dmem[alu_y[DAW+1:2]];

    always_ff @(posedge clk) begin
        if (dm_we_eff) begin
            dmem[alu_y[DAW+1:2]] <= rd_b;
        end
    end

    assign wb_data = ctrl.wb_from_mem ? dmem_rdata : alu_y;

    // next PC selection
    always_comb begin
        if (ctrl.jump) begin
            pc_next = j_target;
        end else if (ctrl.branch && alu_zero) begin
            pc_next = br_target;
        end else begin
            pc_next = pc_plus4;
        end
    end

    assign pc_o        = pc_q;
    assign rf_we_o     = rf_we_eff & (wr_addr != '0);
    assign rf_waddr_o  = wr_addr;
    assign rf_wdata_o  = wb_data;
    assign mem_we_o    = dm_we_eff;
    assign mem_addr_o  = alu_y;
    assign mem_wdata_o = rd_b;

endmodule

// File: rtl/mips_sc_chk.sv
module mips_sc_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_o,
    input logic [31:0] instr,
    input logic        rf_we_o,
    input logic [4:0]  rf_waddr_o,
    input logic        mem_we_o
);
    logic [5:0]  opc;
    logic [31:0] seq_pc;
    logic [31:0] br_off;

    assign opc    = instr[31:26];
    assign seq_pc = pc_o + 32'd4;
    assign br_off = {{14{instr[15]}}, instr[15:0], 2'b00};

    // R1: reset returns the PC to zero
    assert_pc_reset_R1: assert property (@(posedge clk) rst |=> (pc_o == 32'd0));

    // R1: nothing is written while reset is held
    assert_quiet_reset_R1: assert property (@(posedge clk) rst |-> (!rf_we_o && !mem_we_o));

    // R2: non-control instructions step by four
    assert_seq_pc_R2: assert property (@(posedge clk) disable iff (rst)
        (opc != 6'h02 && opc != 6'h04) |=> (pc_o == $past(seq_pc)));

    // R3: R-type writes land in rd
    assert_rtype_dst_R3: assert property (@(posedge clk) disable iff (rst)
        (rf_we_o && opc == 6'h00) |-> (rf_waddr_o == instr[15:11]));

    // R4: register zero never receives a write strobe
    assert_no_r0_write_R4: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> (rf_waddr_o != 5'd0));

    // R5: loads write rt
    assert_load_dst_R5: assert property (@(posedge clk) disable iff (rst)
        (rf_we_o && opc == 6'h23) |-> (rf_waddr_o == instr[20:16]));

    // R6: stores never write a register
    assert_store_no_reg_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> !rf_we_o);

    // R7: beq lands on fall-through or the branch target
    assert_beq_target_R7: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'h04) |=> ((pc_o == $past(seq_pc)) || (pc_o == $past(seq_pc) + $past(br_off))));

    // R8: jump target concatenation
    assert_jump_target_R8: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'h02) |=> (pc_o == {$past(seq_pc[31:28]), $past(instr[25:0]), 2'b00}));

endmodule

bind mips_sc_core mips_sc_chk i_sc_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_o       (pc_o),
    .instr      (instr),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .mem_we_o   (mem_we_o)
);

// File: tb/test_mips_sc_core.sv
module test_mips_sc_core;

    localparam int IW = 64;
    localparam int DW = 64;
    localparam int RUN_CYCLES = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_o;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;
    logic        mem_we_o;
    logic [31:0] mem_addr_o;
    logic [31:0] mem_wdata_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] prog [IW];
    logic [31:0] ref_rf [32];
    logic [31:0] ref_dm [DW];
    logic [31:0] ref_pc;
    string       pc_tag;

    always #5 clk = ~clk;

    mips_sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) i_mips_sc_core (
        .clk(clk), .rst(rst), .pc_o(pc_o), .rf_we_o(rf_we_o),
        .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [25:0] idx);
        return {6'h02, idx};
    endfunction

    function automatic logic [31:0] rand_instr();
        int sel;
        logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
        sel = $urandom_range(0, 9);
        if (sel <= 4) begin
            int k;
            k = $urandom_range(0, 5);
            return enc_r($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
                         (k == 5) ? 6'h00 : fns[k]);
        end else if (sel <= 6) begin
            return enc_i(6'h23, $urandom_range(0, 7), $urandom_range(0, 15), 16'($urandom));
        end else if (sel == 7) begin
            return enc_i(6'h2B, $urandom_range(0, 7), $urandom_range(0, 15), 16'($urandom));
        end else if (sel == 8) begin
            return enc_i(6'h04, $urandom_range(0, 3), $urandom_range(0, 3), 16'($urandom_range(0, 3)));
        end
        return enc_i(6'h08, $urandom_range(0, 15), $urandom_range(1, 15), 16'($urandom));
    endfunction

    // compare the trace of the current cycle with the reference, then advance it
    task automatic ref_cycle();
        logic [31:0] ins, a, b, simm, npc, res, addr;
        logic [5:0]  op, fn;
        int          rs, rt, rd;
        bit          we, mwe, fn_ok;
        int          wa;
        string       tag, ntag;
        ins  = prog[ref_pc[7:2]];
        op   = ins[31:26];
        fn   = ins[5:0];
        rs   = int'(ins[25:21]);
        rt   = int'(ins[20:16]);
        rd   = int'(ins[15:11]);
        simm = {{16{ins[15]}}, ins[15:0]};
        a    = ref_rf[rs];
        b    = ref_rf[rt];
        npc  = ref_pc + 32'd4;
        ntag = "R2";
        we = 1'b0; mwe = 1'b0; wa = 0; res = '0; addr = '0;
        tag = "R2";
        case (op)
            6'h00: begin
                tag = "R3";
                fn_ok = 1'b1;
                case (fn)
                    6'h20: res = a + b;
                    6'h22: res = a - b;
                    6'h24: res = a & b;
                    6'h25: res = a | b;
                    6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: fn_ok = 1'b0;
                endcase
                wa = rd;
                we = fn_ok && (rd != 0);
                if (fn_ok && rd == 0) tag = "R4";
            end
            6'h23: begin
                tag  = (rt == 0) ? "R4" : "R5";
                addr = a + simm;
                res  = ref_dm[addr[7:2]];
                wa   = rt;
                we   = (rt != 0);
            end
            6'h2B: begin
                tag  = "R6";
                addr = a + simm;
                mwe  = 1'b1;
            end
            6'h04: begin
                tag  = "R7";
                ntag = "R7";
                if (a == b) npc = ref_pc + 32'd4 + {simm[29:0], 2'b00};
            end
            6'h02: begin
                tag  = "R8";
                ntag = "R8";
                npc  = {npc[31:28], ins[25:0], 2'b00};
            end
            default: tag = "R2";
        endcase
        chk(pc_o == ref_pc, pc_tag, "pc", pc_o, ref_pc);
        chk(rf_we_o == we, tag, "reg write strobe", 32'(rf_we_o), 32'(we));
        if (we) begin
            chk(rf_waddr_o == 5'(wa), tag, "reg write addr", 32'(rf_waddr_o), 32'(wa));
            chk(rf_wdata_o == res, tag, "reg write data", rf_wdata_o, res);
        end
        chk(mem_we_o == mwe, (op == 6'h2B) ? "R6" : tag, "mem write strobe", 32'(mem_we_o), 32'(mwe));
        if (mwe) begin
            chk(mem_addr_o == addr, "R6", "mem addr", mem_addr_o, addr);
            chk(mem_wdata_o == b, "R6", "mem data", mem_wdata_o, b);
        end
        if (op == 6'h23) begin
            chk(mem_addr_o == addr, "R5", "load addr", mem_addr_o, addr);
        end
        // advance reference
        if (we) ref_rf[wa] = res;
        if (mwe) ref_dm[addr[7:2]] = b;
        ref_pc = npc;
        pc_tag = ntag;
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        repeat (cycles) @(negedge clk);
        #1;
        chk(pc_o == 32'd0, "R1", "pc in reset", pc_o, 32'd0);
        chk(!rf_we_o, "R1", "reg strobe in reset", 32'(rf_we_o), 32'd0);
        chk(!mem_we_o, "R1", "mem strobe in reset", 32'(mem_we_o), 32'd0);
        for (int r = 0; r < 32; r++) ref_rf[r] = '0;
        ref_pc = '0;
        pc_tag = "R1";
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            #1;
            ref_cycle();
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // directed prologue
        prog[0]  = enc_i(6'h23, 0, 1, 16'd0);          // lw r1,0(r0)
        prog[1]  = enc_i(6'h23, 0, 2, 16'd4);          // lw r2,4(r0)
        prog[2]  = enc_r(1, 2, 3, 6'h20);              // add
        prog[3]  = enc_r(1, 2, 4, 6'h22);              // sub
        prog[4]  = enc_r(1, 2, 5, 6'h24);              // and
        prog[5]  = enc_r(1, 2, 6, 6'h25);              // or
        prog[6]  = enc_r(1, 2, 7, 6'h2A);              // slt negative < positive
        prog[7]  = enc_r(2, 1, 8, 6'h2A);              // slt positive < negative
        prog[8]  = enc_i(6'h2B, 0, 3, 16'd8);          // sw r3,8(r0)
        prog[9]  = enc_i(6'h04, 1, 2, 16'd5);          // beq not taken
        prog[10] = enc_i(6'h04, 1, 1, 16'd1);          // beq taken, skips 11
        prog[11] = enc_r(1, 1, 9, 6'h20);
        prog[12] = enc_r(1, 2, 0, 6'h20);              // write to r0 ignored
        prog[13] = enc_i(6'h23, 0, 10, 16'd8);         // lw back stored word
        prog[14] = enc_j(26'd16);                      // jump over 15
        prog[15] = enc_r(1, 1, 11, 6'h20);
        prog[16] = enc_i(6'h23, 0, 12, 16'hFFFC);      // negative offset, wraps
        for (int k = 17; k < 62; k++) prog[k] = rand_instr();
        prog[62] = enc_j(26'd17);
        prog[63] = 32'd0;
        #1;
        for (int k = 0; k < IW; k++) i_mips_sc_core.imem[k] = prog[k];
        for (int k = 0; k < DW; k++) begin
            ref_dm[k] = $urandom;
            i_mips_sc_core.dmem[k] = ref_dm[k];
        end
        ref_dm[0] = 32'h8000_0005;
        ref_dm[1] = 32'h0000_0007;
        i_mips_sc_core.dmem[0] = ref_dm[0];
        i_mips_sc_core.dmem[1] = ref_dm[1];

        do_reset(3);
        run(RUN_CYCLES);
        // second pass: reset mid-run, data memory retained
        do_reset(2);
        run(RUN_CYCLES);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule